// File: doc/BRIEF.md
# Paged Storage Transfer Engine

This block moves whole pages between a page-addressed external store and a small local RAM, without involving the processor core. The local RAM is 128 bytes, seen as 16 pages of 8 bytes. The external store is addressed by a sector and a 16-bit page number and never by byte. One command carries a direction, a sector, a starting external page, a starting RAM page and a page count. The engine then streams the pages one byte at a time. For each page it sends offsets 0 through 7 in order over a valid/ready link to the external side, and it reads or writes the local RAM through its own port.

Consecutive external pages go to consecutive RAM pages. For example, a 3-page import of sector 4, page 167, into RAM page 13 fills RAM pages 13, 14 and 15 from external pages 167, 168 and 169. The byte offset within a page becomes meaningful only once the page is in RAM, which is why the RAM address is built from a 4-bit page number and a 3-bit offset. A command is taken only while the engine is idle. The engine rejects a command whose last page would fall beyond RAM page 15, and it treats a count of zero as an empty command.

Top module: `page_xfer_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, err_o, ext_valid_o, ext_write_o and ram_we_o are 0, and cmd_ready_o is 1.
- R2: A command is accepted on a rising edge where cmd_valid_i and cmd_ready_o are both 1. cmd_ready_o is 0 while busy_o is 1, and cmd_valid_i during that time has no effect on the transfer in progress and starts no later transfer.
- R3: Import (cmd_dir_i = 0) writes each byte taken from ext_rdata_i into RAM at address {RAM page, offset}, with the RAM page in bits 6:3 and the offset in bits 2:0. ram_we_o pulses in the cycle of the byte's handshake, and the offsets of each page go 0 to 7 in order.
- R4: Page k of a transfer (k = 0 … N-1) uses external page P+k modulo 2^16 on ext_page_o and RAM page R+k. ext_sector_o holds the command's sector for the whole transfer, and RAM pages outside R … R+N-1 are not touched.
- R5: Export (cmd_dir_i = 1) presents the RAM byte at {R+k, offset} on ext_wdata_o with ext_write_o = 1, and never asserts ram_we_o.
- R6: A command with a nonzero count N and R+N-1 > 15 is rejected. err_o pulses for one cycle in the cycle after acceptance, no byte is moved, done_o stays 0 and the engine stays idle.
- R7: A command with count 0 moves no byte and sets no error. done_o pulses for one cycle in the cycle after acceptance.
- R8: done_o pulses for exactly one cycle, in the cycle after the handshake of byte 7 of the last page. busy_o is 0 in that same cycle.
- R9: A byte is transferred on a rising edge where ext_valid_o and ext_ready_i are both 1. While ext_ready_i is 0, ext_valid_o, ext_page_o and the RAM address stay unchanged, so stalls of any length are tolerated.
- R10: ext_last_o is 1 exactly for the byte at offset 7 of each page.
- R11: busy_o rises in the cycle after a valid transfer command is accepted and stays 1 until the final handshake. ext_valid_o is 1 only while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_dir_i | input | 1 | 0 import to RAM, 1 export from RAM |
| cmd_sector_i | input | 4 | External sector |
| cmd_ext_page_i | input | 16 | First external page |
| cmd_ram_page_i | input | 4 | First RAM page |
| cmd_count_i | input | 4 | Number of pages, 0 = empty command |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| ext_valid_o | output | 1 | Byte request to external side |
| ext_ready_i | input | 1 | External side takes or supplies the byte |
| ext_write_o | output | 1 | 1 when bytes go to the external store |
| ext_sector_o | output | 4 | Sector of the current transfer |
| ext_page_o | output | 16 | Current external page |
| ext_last_o | output | 1 | Current byte is offset 7 of its page |
| ext_wdata_o | output | 8 | Byte to the external store on export |
| ext_rdata_i | input | 8 | Byte from the external store on import |
| ram_addr_o | output | 7 | Local RAM byte address {page, offset} |
| ram_we_o | output | 1 | Local RAM write enable |
| ram_wdata_o | output | 8 | Local RAM write data |
| ram_rdata_i | input | 8 | Local RAM read data, same-cycle |

## Verification
The embedded assertions check the per-cycle rules on every cycle. They cover the single-cycle done and error pulses, done coinciding with busy falling, RAM writes occurring only on import handshakes, the address holding still during stalls, the offset advancing by one per handshake and the last-byte marker lining up with offset 7. The bench scenarios cover what needs a whole transfer to see. These include the final RAM contents and the export capture, the page mapping at the upper RAM boundary and across external page wrap, the rejection of overflowing and zero-count commands, and commands offered while busy being ignored.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  typedef enum logic {
    DIR_IMPORT = 1'b0,
    DIR_EXPORT = 1'b1
  } dir_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } state_e;
endpackage

// File: rtl/pxe_cmd_check.sv
module pxe_cmd_check #(
  parameter int RAM_PAGES = 16,
  parameter int COUNT_W   = 4,
  localparam int RPAGE_W  = $clog2(RAM_PAGES),
  localparam int SUM_W    = RPAGE_W + COUNT_W + 1
) (
  input  logic [RPAGE_W-1:0] ram_page_i,
  input  logic [COUNT_W-1:0] count_i,
  output logic               empty_o,
  output logic               overflow_o
);
  logic [SUM_W-1:0] end_sum;

  always_comb begin
    end_sum    = SUM_W'(ram_page_i) + SUM_W'(count_i);
    empty_o    = (count_i == '0);
    // last page = start + count - 1 must stay below RAM_PAGES
    overflow_o = !empty_o && (end_sum > SUM_W'(RAM_PAGES));
  end
endmodule

// File: rtl/pxe_seq.sv
module pxe_seq
  import pxe_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int COUNT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               step_i,
  output logic               busy_o,
  output logic [OFF_W-1:0]   byte_idx_o,
  output logic [COUNT_W-1:0] page_idx_o,
  output logic               last_byte_o,
  output logic               finish_o
);
  state_e             state_q;
  logic [COUNT_W-1:0] cnt_q;
  logic [OFF_W-1:0]   byte_q;
  logic [COUNT_W-1:0] page_q;
  logic               last_page;

  always_comb begin
    busy_o      = (state_q == ST_MOVE);
    last_byte_o = (byte_q == '1);
    last_page   = (page_q == cnt_q - COUNT_W'(1));
    finish_o    = busy_o && step_i && last_byte_o && last_page;
    byte_idx_o  = byte_q;
    page_idx_o  = page_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      page_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MOVE;
          cnt_q   <= count_i;
          byte_q  <= '0;
          page_q  <= '0;
        end
        ST_MOVE: if (step_i) begin
          byte_q <= byte_q + OFF_W'(1);
          if (last_byte_o) page_q <= page_q + COUNT_W'(1);
          if (finish_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r11_start_clears_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && byte_idx_o == '0 && page_idx_o == '0));

  a_r8_finish_goes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !busy_o);
endmodule

// File: rtl/pxe_dpath.sv
module pxe_dpath
  import pxe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int RAM_PAGES  = 16,
  parameter int EXT_PAGE_W = 16,
  parameter int SECTOR_W   = 4,
  parameter int COUNT_W    = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int RPAGE_W   = $clog2(RAM_PAGES),
  localparam int RAM_AW    = RPAGE_W + OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  dir_i,
  input  logic [SECTOR_W-1:0]   sector_i,
  input  logic [EXT_PAGE_W-1:0] ext_page_i,
  input  logic [RPAGE_W-1:0]    ram_page_i,
  input  logic                  busy_i,
  input  logic                  step_i,
  input  logic [OFF_W-1:0]      byte_idx_i,
  input  logic [COUNT_W-1:0]    page_idx_i,
  output logic                  ext_write_o,
  output logic [SECTOR_W-1:0]   ext_sector_o,
  output logic [EXT_PAGE_W-1:0] ext_page_o,
  output logic [DATA_W-1:0]     ext_wdata_o,
  input  logic [DATA_W-1:0]     ext_rdata_i,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [DATA_W-1:0]     ram_wdata_o,
  input  logic [DATA_W-1:0]     ram_rdata_i
);
  dir_e                  dir_q;
  logic [SECTOR_W-1:0]   sector_q;
  logic [EXT_PAGE_W-1:0] ext_base_q;
  logic [RPAGE_W-1:0]    ram_base_q;
  logic [RPAGE_W-1:0]    idx_r;
  logic [RPAGE_W-1:0]    ram_pg;

  generate
    if (COUNT_W >= RPAGE_W) begin : g_idx_trunc
      assign idx_r = page_idx_i[RPAGE_W-1:0];
    end else begin : g_idx_ext
      assign idx_r = {{(RPAGE_W-COUNT_W){1'b0}}, page_idx_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q      <= DIR_IMPORT;
      sector_q   <= '0;
      ext_base_q <= '0;
      ram_base_q <= '0;
    end else if (load_i) begin
      dir_q      <= dir_e'(dir_i);
      sector_q   <= sector_i;
      ext_base_q <= ext_page_i;
      ram_base_q <= ram_page_i;
    end
  end

  always_comb begin
    ram_pg       = ram_base_q + idx_r;
    ext_sector_o = sector_q;
    ext_page_o   = ext_base_q + EXT_PAGE_W'(page_idx_i);
    ext_write_o  = busy_i && (dir_q == DIR_EXPORT);
    ext_wdata_o  = ext_write_o ? ram_rdata_i : '0;
    ram_addr_o   = busy_i ? {ram_pg, byte_idx_i} : '0;
    ram_we_o     = step_i && (dir_q == DIR_IMPORT);
    ram_wdata_o  = ext_rdata_i;
  end

  a_r5_no_write_on_export: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_write_o |-> !ram_we_o);
endmodule

// File: rtl/page_xfer_engine.sv
module page_xfer_engine
  import pxe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int RAM_PAGES  = 16,
  parameter int EXT_PAGE_W = 16,
  parameter int SECTOR_W   = 4,
  parameter int COUNT_W    = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int RPAGE_W   = $clog2(RAM_PAGES),
  localparam int RAM_AW    = RPAGE_W + OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic                  cmd_dir_i,
  input  logic [SECTOR_W-1:0]   cmd_sector_i,
  input  logic [EXT_PAGE_W-1:0] cmd_ext_page_i,
  input  logic [RPAGE_W-1:0]    cmd_ram_page_i,
  input  logic [COUNT_W-1:0]    cmd_count_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  ext_valid_o,
  input  logic                  ext_ready_i,
  output logic                  ext_write_o,
  output logic [SECTOR_W-1:0]   ext_sector_o,
  output logic [EXT_PAGE_W-1:0] ext_page_o,
  output logic                  ext_last_o,
  output logic [DATA_W-1:0]     ext_wdata_o,
  input  logic [DATA_W-1:0]     ext_rdata_i,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [DATA_W-1:0]     ram_wdata_o,
  input  logic [DATA_W-1:0]     ram_rdata_i
);
  logic               accept, empty, overflow, start, step, finish, busy;
  logic               done_q, err_q;
  logic [OFF_W-1:0]   byte_idx;
  logic [COUNT_W-1:0] page_idx;

  assign cmd_ready_o = !busy;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign start       = accept && !empty && !overflow;
  assign step        = busy && ext_ready_i;
  assign busy_o      = busy;
  assign ext_valid_o = busy;
  assign done_o      = done_q;
  assign err_o       = err_q;

  pxe_cmd_check #(
    .RAM_PAGES (RAM_PAGES),
    .COUNT_W   (COUNT_W)
  ) u_check (
    .ram_page_i (cmd_ram_page_i),
    .count_i    (cmd_count_i),
    .empty_o    (empty),
    .overflow_o (overflow)
  );

  pxe_seq #(
    .OFF_W   (OFF_W),
    .COUNT_W (COUNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .count_i     (cmd_count_i),
    .step_i      (step),
    .busy_o      (busy),
    .byte_idx_o  (byte_idx),
    .page_idx_o  (page_idx),
    .last_byte_o (ext_last_o),
    .finish_o    (finish)
  );

  pxe_dpath #(
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .RAM_PAGES  (RAM_PAGES),
    .EXT_PAGE_W (EXT_PAGE_W),
    .SECTOR_W   (SECTOR_W),
    .COUNT_W    (COUNT_W)
  ) u_dpath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start),
    .dir_i        (cmd_dir_i),
    .sector_i     (cmd_sector_i),
    .ext_page_i   (cmd_ext_page_i),
    .ram_page_i   (cmd_ram_page_i),
    .busy_i       (busy),
    .step_i       (step),
    .byte_idx_i   (byte_idx),
    .page_idx_i   (page_idx),
    .ext_write_o  (ext_write_o),
    .ext_sector_o (ext_sector_o),
    .ext_page_o   (ext_page_o),
    .ext_wdata_o  (ext_wdata_o),
    .ext_rdata_i  (ext_rdata_i),
    .ram_addr_o   (ram_addr_o),
    .ram_we_o     (ram_we_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_rdata_i  (ram_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= finish || (accept && empty);
      err_q  <= accept && overflow;
    end
  end

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_on_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r6_err_single_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));

  a_r6_err_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(busy_o));

  a_r3_offset_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && ext_ready_i && !ext_last_o)
      |=> (ext_valid_o && ram_addr_o == $past(ram_addr_o) + RAM_AW'(1)));

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !ext_ready_i)
      |=> (ext_valid_o && $stable(ext_page_o) && $stable(ram_addr_o)));

  a_r3_we_on_import_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ext_valid_o && ext_ready_i && !ext_write_o));

  a_r10_last_at_top_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && ext_last_o) |-> (ram_addr_o[OFF_W-1:0] == '1));

  a_r2_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o);
endmodule

// File: tb/page_xfer_engine_bench.sv
module page_xfer_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready, cmd_dir = 1'b0;
  logic [3:0]  cmd_sector = '0, cmd_ram_page = '0, cmd_count = '0;
  logic [15:0] cmd_ext_page = '0;
  logic        busy, done, err, ext_valid, ext_ready = 1'b1, ext_write, ext_last;
  logic [3:0]  ext_sector;
  logic [15:0] ext_page;
  logic [7:0]  ext_wdata, ext_rdata, ram_wdata, ram_rdata;
  logic [6:0]  ram_addr;
  logic        ram_we;

  page_xfer_engine u_page_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_dir_i(cmd_dir),
    .cmd_sector_i(cmd_sector), .cmd_ext_page_i(cmd_ext_page),
    .cmd_ram_page_i(cmd_ram_page), .cmd_count_i(cmd_count),
    .busy_o(busy), .done_o(done), .err_o(err),
    .ext_valid_o(ext_valid), .ext_ready_i(ext_ready), .ext_write_o(ext_write),
    .ext_sector_o(ext_sector), .ext_page_o(ext_page), .ext_last_o(ext_last),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [7:0] ext_byte(input logic [3:0] s, input logic [15:0] p,
                                          input logic [2:0] o);
    return 8'(p[7:0] + 8'(p[15:8]) * 8'd3 + 8'(o) * 8'd29 + 8'(s) * 8'd7 + 8'd1);
  endfunction

  function automatic logic [7:0] sentinel(input int i);
    return 8'(i * 5 + 1) ^ 8'hA0;
  endfunction

  // local RAM model, same-cycle read
  logic [7:0] ram [128];
  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  // external side and handshake monitor
  logic [15:0] exp_p = '0;
  logic [3:0]  exp_r = '0, exp_s = '0;
  logic        exp_dir = 1'b0;
  logic [2:0]  hs_off = '0;
  int          hs_k = 0, hs_n = 0, mon_err = 0;
  logic [7:0]  cap [128];
  assign ext_rdata = ext_byte(ext_sector, ext_page, hs_off);

  always @(posedge clk) begin
    if (ext_valid && ext_ready) begin
      if (ext_page !== 16'(exp_p + 16'(hs_k))) mon_err <= mon_err + 1;
      if (ram_addr !== {4'(exp_r + 4'(hs_k)), hs_off}) mon_err <= mon_err + 1;
      if (ext_last !== (hs_off == 3'd7)) mon_err <= mon_err + 1;
      if (ext_write !== exp_dir || ext_sector !== exp_s) mon_err <= mon_err + 1;
      if (ram_we && exp_dir) mon_err <= mon_err + 1;
      if (exp_dir) cap[8 * hs_k + 32'(hs_off)] <= ext_wdata;
      hs_n   <= hs_n + 1;
      hs_off <= hs_off + 3'd1;
      if (hs_off == 3'd7) hs_k <= hs_k + 1;
    end else if (ram_we) mon_err <= mon_err + 1;
  end

  int rmode = 0, ph = 0;
  always @(negedge clk) begin
    ph <= ph + 1;
    case (rmode)
      1:       ext_ready <= (ph % 2 == 0);
      2:       ext_ready <= (ph % 3 == 0);
      default: ext_ready <= 1'b1;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic prefill();
    for (int i = 0; i < 128; i++) ram[i] = sentinel(i);
  endtask

  task automatic issue(input logic d, input logic [3:0] s, input logic [15:0] p,
                       input logic [3:0] r, input logic [3:0] n);
    @(negedge clk);
    exp_p = p; exp_r = r; exp_s = s; exp_dir = d;
    hs_off = '0; hs_k = 0; hs_n = 0; mon_err = 0;
    cmd_dir = d; cmd_sector = s; cmd_ext_page = p; cmd_ram_page = r; cmd_count = n;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 3000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic finish_checks(input int n);
    wait_done();
    chk(done === 1'b1, "R8 done seen", int'(done), 1);
    chk(busy === 1'b0, "R8 busy low with done", int'(busy), 0);
    chk(hs_n == 8 * n, "R3 byte count", hs_n, 8 * n);
    chk(mon_err == 0, "R4 R9 R10 per-byte mapping", mon_err, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 single pulse", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({busy, done, err, ext_valid, ext_write, ram_we} === 6'b0, "R1 reset outputs",
        int'({busy, done, err, ext_valid, ext_write, ram_we}), 0);
    chk(cmd_ready === 1'b1, "R1 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_import(input logic [3:0] s, input logic [15:0] p, input logic [3:0] r,
                          input logic [3:0] n, input int mode);
    int bad = 0;
    prefill();
    rmode = mode;
    issue(1'b0, s, p, r, n);
    chk(busy === 1'b1, "R11 busy after accept", int'(busy), 1);
    finish_checks(int'(n));
    for (int i = 0; i < 128; i++) begin
      int pg = i / 8;
      logic [7:0] e;
      if (pg >= int'(r) && pg < int'(r) + int'(n))
        e = ext_byte(s, 16'(p + 16'(pg - int'(r))), 3'(i % 8));
      else
        e = sentinel(i);
      if (ram[i] !== e) bad++;
    end
    chk(bad == 0, "R3 R4 import RAM contents", bad, 0);
  endtask

  task automatic t_export(input logic [3:0] s, input logic [15:0] p, input logic [3:0] r,
                          input logic [3:0] n, input int mode);
    int bad = 0, chg = 0;
    prefill();
    rmode = mode;
    issue(1'b1, s, p, r, n);
    chk(busy === 1'b1, "R11 busy after accept", int'(busy), 1);
    finish_checks(int'(n));
    for (int i = 0; i < 8 * int'(n); i++)
      if (cap[i] !== sentinel(8 * int'(r) + i)) bad++;
    for (int i = 0; i < 128; i++) if (ram[i] !== sentinel(i)) chg++;
    chk(bad == 0, "R5 export data", bad, 0);
    chk(chg == 0, "R5 RAM untouched on export", chg, 0);
  endtask

  task automatic t_overflow();
    int chg = 0, seen_done = 0;
    prefill();
    rmode = 0;
    issue(1'b0, 4'd1, 16'd50, 4'd14, 4'd3);
    chk(err === 1'b1, "R6 err pulse", int'(err), 1);
    chk(busy === 1'b0, "R6 stays idle", int'(busy), 0);
    @(negedge clk);
    chk(err === 1'b0, "R6 err single cycle", int'(err), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || busy) seen_done++;
    end
    for (int i = 0; i < 128; i++) if (ram[i] !== sentinel(i)) chg++;
    chk(hs_n == 0 && chg == 0, "R6 nothing moved", hs_n + chg, 0);
    chk(seen_done == 0, "R6 no done or busy", seen_done, 0);
  endtask

  task automatic t_zero();
    issue(1'b0, 4'd3, 16'd9, 4'd2, 4'd0);
    chk(done === 1'b1 && err === 1'b0 && busy === 1'b0, "R7 empty command done",
        int'({done, err, busy}), 4);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single cycle", int'(done), 0);
    repeat (10) @(negedge clk);
    chk(hs_n == 0, "R7 no bytes", hs_n, 0);
  endtask

  task automatic t_busy_ignore();
    int bad = 0, late = 0;
    prefill();
    rmode = 2;
    issue(1'b0, 4'd2, 16'd100, 4'd0, 4'd2);
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b0, "R2 not ready while busy", int'(cmd_ready), 0);
    cmd_dir = 1'b0; cmd_ram_page = 4'd8; cmd_count = 4'd1; cmd_ext_page = 16'd7;
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    finish_checks(2);
    for (int i = 64; i < 72; i++) if (ram[i] !== sentinel(i)) bad++;
    chk(bad == 0, "R2 second command ignored", bad, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) late++;
    end
    chk(late == 0, "R2 no late transfer", late, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_import(4'd4, 16'd167, 4'd13, 4'd3, 0);    // R4 upper RAM edge
    t_import(4'd9, 16'hFFFF, 4'd6, 4'd2, 1);    // R4 external page wrap, R9 stalls
    t_import(4'd0, 16'h1234, 4'd15, 4'd1, 2);   // R4 last page only
    t_import(4'd15, 16'h0400, 4'd0, 4'd15, 0);  // R4 full-length transfer
    t_export(4'd5, 16'h00A0, 4'd3, 4'd4, 1);
    t_export(4'd1, 16'h8000, 4'd12, 4'd4, 2);
    t_overflow();
    t_zero();
    t_busy_ignore();
    summary();
  end
endmodule